// File: doc/BRIEF.md
# Cascaded Clock Source Selector and Divider

This block derives one output clock from four independent input clocks. A 32-bit control word sets three things: which input feeds the output, a pre-division ratio of 1 to 32, and a post-division ratio of 1 to 4. The pre-divider sits only in the path of the highest-numbered input. The other three inputs reach the post-divider directly. The output frequency is therefore the chosen input divided by the post ratio, and also by the pre ratio when input 3 is chosen.

The control word lives in the register clock domain. It can be changed in two ways: a full-word write, or a field update that replaces only the two ratio fields and keeps every other bit, so no read-modify-write is needed. The source is changed through a break-before-make handshake: the old clock is stopped in its low phase before the new one is let through. Each divider takes a new ratio only at the end of one of its own output periods, so a ratio change never leaves a runt pulse.

Top module: `cascade_clk_div`

## Requirements
- R1: After reset the control word reads 0x00000000, and the output follows input 0 undivided.
- R2: Control bits 17:16 hold a value s from 0 to 3, and the output is derived from input clock s.
- R3: With s = 3, control bits 12:8 hold a value v, and input 3 is divided by v+1 (1 to 32) before the post-divider.
- R4: With s = 0, 1 or 2, the value in bits 12:8 has no effect on the output.
- R5: Control bits 5:4 hold a value v, and the post-divider divides its input by v+1 (1 to 4) for every source.
- R6: A divide stage with ratio N of 2 or more holds its output high for floor(N/2) of its input periods and low for the rest. A stage with N = 1 passes its input through unchanged.
- R7: A field update writes only bits 12:8 (from the pre value) and bits 5:4 (from the post value), leaving all other bits as they were. When it coincides with a full-word write, the two fields are laid over the written word.
- R8: Bits outside 17:16, 12:8 and 5:4 read back as written and have no effect on the output. Without a write the word holds its value.
- R9: Only one input is ever enabled at a time. The old input is disabled during its low phase before the new one is enabled, so the output has no pulse shorter than half a period of the faster input involved.
- R10: A divide stage takes a new ratio only at the end of a full output period at its current ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of every input clock |
| src_clk | input | 4 | The four candidate input clocks; bit 3 passes through the pre-divider |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Full-word write value |
| fld_wr | input | 1 | Ratio-field update strobe |
| fld_pre | input | 5 | New pre-divider field (ratio minus one) |
| fld_post | input | 2 | New post-divider field (ratio minus one) |
| rd_data | output | 32 | Current control word |
| clk_out | output | 1 | Selected and divided output clock |

## Verification
A corrupted control word appears on rd_data one register-clock cycle after the faulty write. A wrong counter or ratio state in either divider changes the measured period or high time of clk_out within one output period, once the synchronizers have settled. A fault in the switching handshake appears at clk_out during the changeover, as a pulse narrower than half a period of the faster input. Monitoring pulse width across several source switches catches that fault within a few input periods.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W    = 32;
  localparam int SEL_LSB  = 16;
  localparam int SEL_W    = 2;
  localparam int PRE_LSB  = 8;
  localparam int PRE_W    = 5;
  localparam int POST_LSB = 4;
  localparam int POST_W   = 2;
  localparam int NUM_SRC  = 1 << SEL_W;
  localparam int PRE_SRC  = NUM_SRC - 1;
  localparam logic [REG_W-1:0] RATIO_MASK =
      REG_W'(((1 << PRE_W) - 1) << PRE_LSB) | REG_W'(((1 << POST_W) - 1) << POST_LSB);
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              fld_wr,
  input  logic [PRE_W-1:0]  fld_pre,
  input  logic [POST_W-1:0] fld_post,
  output logic [REG_W-1:0]  q
);
  logic [REG_W-1:0] nxt;

  always_comb begin
    nxt = wr_en ? wr_data : q;
    if (fld_wr) begin
      nxt[PRE_LSB +: PRE_W]   = fld_pre;
      nxt[POST_LSB +: POST_W] = fld_post;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/clkdiv_cfg_sync.sv
module clkdiv_cfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES+1];

  // The value is passed on only once two consecutive synchronized samples agree.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= STAGES; k++) stg[k] <= '0;
      q <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k <= STAGES; k++) stg[k] <= stg[k-1];
      if (stg[STAGES] == stg[STAGES-1]) q <= stg[STAGES];
    end
  end
endmodule

// File: rtl/clkdiv_ratio_div.sv
module clkdiv_ratio_div #(
  parameter int W = 5
) (
  input  logic         clk_in,
  input  logic         rst,
  input  logic [W-1:0] ratio_m1,
  output logic         clk_out,
  output logic         at_end,
  output logic [W-1:0] cur_m1
);
  logic [W-1:0] cnt;
  logic         q;
  logic         byp;
  logic [W:0]   half;
  logic [W:0]   cnt_inc;

  assign at_end  = (cnt == cur_m1);
  assign half    = ({1'b0, cur_m1} + (W+1)'(1)) >> 1;
  assign cnt_inc = {1'b0, cnt} + (W+1)'(1);

  always_ff @(posedge clk_in) begin
    if (rst) begin
      cnt    <= '0;
      cur_m1 <= '0;
      q      <= 1'b0;
      byp    <= 1'b1;
    end else if (at_end) begin
      // Period boundary: the only point where a new ratio is taken.
      cnt    <= '0;
      cur_m1 <= ratio_m1;
      byp    <= (ratio_m1 == '0);
      q      <= (ratio_m1 != '0);
    end else begin
      cnt <= cnt_inc[W-1:0];
      q   <= (cnt_inc < half);
    end
  end

  assign clk_out = byp ? clk_in : q;
endmodule

// File: rtl/clkdiv_glitchless_mux.sv
module clkdiv_glitchless_mux #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic [N-1:0]     clk_in,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     en_o,
  output logic             clk_out
);
  logic [N-1:0] en;
  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic s1;
    logic s2;
    logic en_q;
    logic others;

    assign others = |(en & ~(N'(1) << i));

    always_ff @(posedge clk_in[i]) begin
      if (rst) begin
        s1 <= (i == 0);
        s2 <= (i == 0);
      end else begin
        s1 <= (sel == SEL_W'(i)) && !others;
        s2 <= s1;
      end
    end

    // The enable changes on the falling edge, while this clock is low.
    always_ff @(negedge clk_in[i]) begin
      if (rst) en_q <= (i == 0);
      else     en_q <= s2;
    end

    assign en[i]    = en_q;
    assign gated[i] = clk_in[i] & en_q;
  end

  assign en_o    = en;
  assign clk_out = |gated;
endmodule

// File: rtl/cascade_clk_div.sv
module cascade_clk_div
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               fld_wr,
  input  logic [PRE_W-1:0]   fld_pre,
  input  logic [POST_W-1:0]  fld_post,
  output logic [REG_W-1:0]   rd_data,
  output logic               clk_out
);
  logic [REG_W-1:0]   ctrl;
  logic [PRE_W-1:0]   pre_sync;
  logic [POST_W-1:0]  post_sync;
  logic               pre_clk;
  logic               pre_end;
  logic [PRE_W-1:0]   pre_cur;
  logic [NUM_SRC-1:0] mux_in;
  logic [NUM_SRC-1:0] src_en;
  logic               mux_clk;
  logic               post_end;
  logic [POST_W-1:0]  post_cur;

  clkdiv_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fld_wr(fld_wr), .fld_pre(fld_pre), .fld_post(fld_post), .q(ctrl)
  );

  assign rd_data = ctrl;

  clkdiv_cfg_sync #(.W(PRE_W), .STAGES(SYNC_STAGES)) u_pre_sync (
    .clk(src_clk[PRE_SRC]), .rst(rst), .d(ctrl[PRE_LSB +: PRE_W]), .q(pre_sync)
  );

  clkdiv_ratio_div #(.W(PRE_W)) u_pre_div (
    .clk_in(src_clk[PRE_SRC]), .rst(rst), .ratio_m1(pre_sync),
    .clk_out(pre_clk), .at_end(pre_end), .cur_m1(pre_cur)
  );

  assign mux_in = {pre_clk, src_clk[PRE_SRC-1:0]};

  clkdiv_glitchless_mux #(.N(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .clk_in(mux_in), .rst(rst), .sel(ctrl[SEL_LSB +: SEL_W]),
    .en_o(src_en), .clk_out(mux_clk)
  );

  clkdiv_cfg_sync #(.W(POST_W), .STAGES(SYNC_STAGES)) u_post_sync (
    .clk(mux_clk), .rst(rst), .d(ctrl[POST_LSB +: POST_W]), .q(post_sync)
  );

  clkdiv_ratio_div #(.W(POST_W)) u_post_div (
    .clk_in(mux_clk), .rst(rst), .ratio_m1(post_sync),
    .clk_out(clk_out), .at_end(post_end), .cur_m1(post_cur)
  );
endmodule

// File: rtl/cascade_clk_div_chk.sv
module cascade_clk_div_chk
  import clkdiv_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               fld_wr,
  input logic [REG_W-1:0]   rd_data,
  input logic [NUM_SRC-1:0] src_en,
  input logic               pre_src_clk,
  input logic               pre_end,
  input logic [PRE_W-1:0]   pre_cur,
  input logic               mux_clk,
  input logic               post_end,
  input logic [POST_W-1:0]  post_cur
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

  assert_field_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (fld_wr && !wr_en) |=> ((rd_data & ~RATIO_MASK) == ($past(rd_data) & ~RATIO_MASK)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !fld_wr) |=> $stable(rd_data));

  assert_one_source_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_en));

  assert_post_load_R10: assert property (@(posedge mux_clk) disable iff (rst)
    !post_end |=> $stable(post_cur));

  assert_pre_load_R10: assert property (@(posedge pre_src_clk) disable iff (rst)
    !pre_end |=> $stable(pre_cur));
endmodule

bind cascade_clk_div cascade_clk_div_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .fld_wr(fld_wr), .rd_data(rd_data),
  .src_en(src_en), .pre_src_clk(src_clk[NUM_SRC-1]), .pre_end(pre_end),
  .pre_cur(pre_cur), .mux_clk(mux_clk), .post_end(post_end), .post_cur(post_cur)
);

// File: tb/cascade_clk_div_tb.sv
`timescale 1ns/1ps
module cascade_clk_div_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        fld_wr = 1'b0;
  logic [4:0]  fld_pre = '0;
  logic [1:0]  fld_post = '0;
  logic [31:0] rd_data;
  logic        clk_out;

  int n_checks = 0;
  int n_fail = 0;
  real per [4] = '{8.0, 12.0, 20.0, 6.0};
  real last_edge = 0.0;
  real minw = 1.0e9;
  bit  mon = 1'b0;

  always #5 clk = ~clk;
  always #4 s0 = ~s0;
  always #6 s1 = ~s1;
  always #10 s2 = ~s2;
  always #3 s3 = ~s3;

  cascade_clk_div u_dut (
    .clk(clk), .rst(rst), .src_clk({s3, s2, s1, s0}),
    .wr_en(wr_en), .wr_data(wr_data), .fld_wr(fld_wr),
    .fld_pre(fld_pre), .fld_post(fld_post), .rd_data(rd_data), .clk_out(clk_out)
  );

  // Narrowest pulse seen on the output while monitoring is on.
  always @(clk_out) begin
    if (mon && ($realtime - last_edge) < minw) minw = $realtime - last_edge;
    last_edge = $realtime;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic check_word(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic check_real(string tag, real act, real exp);
    n_checks++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      n_fail++;
      $display("FAIL %s: actual %0.3f expected %0.3f", tag, act, exp);
    end
  endtask

  task automatic check_min(string tag, real act, real lim);
    n_checks++;
    if (act < lim - 0.01) begin
      n_fail++;
      $display("FAIL %s: actual min pulse %0.3f expected at least %0.3f", tag, act, lim);
    end
  endtask

  task automatic write_full(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic write_fields(logic [4:0] p, logic [1:0] q);
    @(negedge clk); fld_wr = 1'b1; fld_pre = p; fld_post = q;
    @(negedge clk); fld_wr = 1'b0;
  endtask

  function automatic logic [31:0] word(int s, int p, int q);
    return (32'(s) << 16) | (32'(p - 1) << 8) | (32'(q - 1) << 4);
  endfunction

  // Expected period and high time from the ratio rules alone.
  task automatic check_rate(string tag, int s, int p, int q);
    real t0, t1, t2, tin, hin;
    #12000;
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    tin = per[s];
    hin = tin / 2.0;
    if (s == 3 && p > 1) begin
      hin = real'(p / 2) * per[3];
      tin = per[3] * real'(p);
    end
    check_real({tag, " period"}, t2 - t0, tin * real'(q));
    check_real({tag, " high"}, t1 - t0, (q == 1) ? hin : real'(q / 2) * tin);
  endtask

  task automatic t_reset();
    check_word("R1 reset word", rd_data, 32'h0);
    check_rate("R1 R6 reset output source 0 ratio 1", 0, 1, 1);
  endtask

  task automatic t_post_div();
    write_full(word(0, 1, 3));
    check_rate("R5 R6 post ratio 3", 0, 1, 3);
    write_full(word(0, 1, 4));
    check_rate("R5 post ratio 4", 0, 1, 4);
  endtask

  task automatic t_select();
    write_full(word(1, 1, 1));
    check_rate("R2 source 1", 1, 1, 1);
    write_full(word(2, 1, 2));
    check_rate("R2 R5 source 2 post 2", 2, 1, 2);
  endtask

  task automatic t_pre();
    write_full(word(3, 5, 2));
    check_rate("R3 pre 5 post 2", 3, 5, 2);
    write_full(word(3, 32, 4));
    check_rate("R3 pre 32 post 4", 3, 32, 4);
    write_full(word(3, 3, 1));
    check_rate("R3 R6 odd pre 3", 3, 3, 1);
  endtask

  task automatic t_pre_ignored();
    write_full(word(1, 32, 1));
    check_rate("R4 pre ignored on source 1", 1, 1, 1);
  endtask

  task automatic t_field_write();
    write_full(32'hFFFF_FFFF);
    check_word("R8 all ones read back", rd_data, 32'hFFFF_FFFF);
    write_fields(5'd3, 2'd1);
    check_word("R7 field update keeps other bits", rd_data, 32'hFFFF_E3DF);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h0003_0000;
    fld_wr = 1'b1; fld_pre = 5'd2; fld_post = 2'd2;
    @(negedge clk); wr_en = 1'b0; fld_wr = 1'b0;
    check_word("R7 fields over full write", rd_data, 32'h0003_0220);
    check_rate("R7 R6 pre 3 post 3", 3, 3, 3);
  endtask

  task automatic t_unassigned();
    write_full(32'hFFFC_E0CF);
    check_word("R8 unassigned bits read back", rd_data, 32'hFFFC_E0CF);
    check_rate("R8 unassigned bits no effect", 0, 1, 1);
  endtask

  task automatic t_switch();
    write_full(word(0, 1, 1));
    #12000;
    minw = 1.0e9; mon = 1'b1;
    write_full(word(1, 1, 1));
    #3000;
    write_full(word(3, 1, 1));
    #3000;
    write_full(word(0, 1, 1));
    #3000;
    mon = 1'b0;
    check_min("R9 no runt pulse across source switches", minw, 3.0);
    check_rate("R9 back on source 0", 0, 1, 1);
  endtask

  task automatic t_boundary();
    write_full(word(1, 1, 4));
    #12000;
    minw = 1.0e9; mon = 1'b1;
    write_fields(5'd0, 2'd1);
    #3000;
    mon = 1'b0;
    check_min("R10 ratio change at period boundary", minw, 12.0);
    check_rate("R10 new post ratio 2", 1, 1, 2);
  endtask

  initial begin
    #1_800_000;
    n_fail++;
    $display("FAIL watchdog: actual run still active, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (20) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_post_div();
    t_select();
    t_pre();
    t_pre_ignored();
    t_field_write();
    t_unassigned();
    t_switch();
    t_boundary();
    summary();
    $finish;
  end
endmodule